// File: doc/BRIEF.md
# Back-end trigger realignment relay

This block sits on the path from the central timing master to the back-end readout boards. One 44-bit command word arrives on every bunch crossing. The trigger decision, its type and the packet destination in that word do not describe the crossing whose bunch ID is carried next to them. They arrive a fixed number of crossings later. The relay holds back the crossing-bound fields (bunch ID, control bits, reserved bits) in a delay pipeline of programmable depth. It then joins them with the trigger fields that belong to them, so that each word it sends downstream is self-consistent and leaves at constant latency.

The delay depth, from 0 to 255 crossings, is loaded through a one-cycle write strobe. After each load the output is held idle until the pipeline has refilled at the new depth. In the other direction, the relay samples one throttle bit from each of 16 back-end boards on every crossing. It returns the whole vector upstream, together with a single summary bit that is set when any board is throttling.

Top module: `trig_realign_relay`

## Requirements
- R1: While reset is held and on the first output after it, cmd_valid, cmd_out, thr_vec and thr_any are all zero.
- R2: Within the word, bit 20 is the trigger, bits [24:21] the trigger type and bits [40:25] the packet destination; together these bits [40:20] form the late group. Bits [11:0] (bunch ID), [19:12] (control) and [43:41] (reserved) form the early group.
- R3: While cmd_valid is 1, cmd_out[40:20] equals cmd_in[40:20] sampled on the previous clock edge.
- R4: With depth D, where 1 ≤ D ≤ 255, while cmd_valid is 1 the early group of cmd_out equals the early group of the word sampled D+1 edges earlier.
- R5: With depth 0, while cmd_valid is 1 the whole cmd_out equals the cmd_in word sampled on the previous edge.
- R6: A depth write of N sampled at edge k makes cmd_valid 0 after edges k through k+N and 1 again after edge k+N+1, unless another write intervenes. The delay depth after reset is 0.
- R7: Whenever cmd_valid is 0, cmd_out is all zeros.
- R8: thr_vec equals thr_in sampled on the previous clock edge; bit i belongs to board i.
- R9: thr_any is the OR of all bits of thr_vec in the same cycle.
- R10: The largest depth, 255, realigns correctly, with the early group taken from the word 256 edges back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one word per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in | input | 44 | Command word from the timing master |
| depth_we | input | 1 | Strobe that loads a new delay depth |
| depth_wdata | input | 8 | Delay depth in crossings |
| thr_in | input | 16 | Throttle bit from each back-end board |
| cmd_out | output | 44 | Realigned command word to the back end |
| cmd_valid | output | 1 | Realigned word is valid (0 while refilling) |
| thr_vec | output | 16 | Registered throttle vector sent upstream |
| thr_any | output | 1 | Set when any board is throttling |

## Verification
The bench loads a sweep of depths that includes 0, 1, the maximum 255, a reload of the same value and a reload made while the pipeline is still refilling. After each load it compares every output word against a history it keeps itself. If a design's read pointer is off by one, the early fields show up one crossing early or late at every depth. A design without the zero-depth bypass would emit stale bunch IDs at depth 0. A design whose refill count is short would release a valid word before the pipeline has caught up. A design whose pointer wraps wrongly would only fail at 255. Walking-one, all-zero and all-one throttle patterns catch swapped board bits and a summary bit taken from the wrong cycle.

// File: rtl/trig_relay_pkg.sv
package trig_relay_pkg;
  localparam int WORD_W  = 44;
  localparam int LATE_LO = 20;
  localparam int LATE_HI = 40;
  localparam int LATE_W  = LATE_HI - LATE_LO + 1;
  localparam int RSV_LO  = LATE_HI + 1;
  localparam int RSV_W   = WORD_W - RSV_LO;
  localparam int EARLY_W = LATE_LO + RSV_W;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [LATE_W-1:0]  late_t;
  typedef logic [EARLY_W-1:0] early_t;

  // crossing-bound fields: reserved on top, bunch id and control below
  function automatic early_t early_of(input word_t w);
    return {w[WORD_W-1:RSV_LO], w[LATE_LO-1:0]};
  endfunction

  // trigger, trigger type and destination
  function automatic late_t late_of(input word_t w);
    return w[LATE_HI:LATE_LO];
  endfunction

  function automatic word_t join_word(input early_t e, input late_t l);
    return {e[EARLY_W-1:LATE_LO], l, e[LATE_LO-1:0]};
  endfunction
endpackage

// File: rtl/field_delay_line.sv
module field_delay_line #(
  parameter int DW = 23,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] depth,
  output logic [DW-1:0] dout
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= wr_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    mem[wr_ptr] <= din;
  end

  assign rd_ptr = wr_ptr - depth;
  assign dout   = (depth == '0) ? din : mem[rd_ptr];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ptr == $past(wr_ptr) + 1'b1); // R4
endmodule

// File: rtl/refill_guard.sv
module refill_guard #(
  parameter int DEPTH_W       = 8,
  parameter int DEFAULT_DEPTH = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [DEPTH_W-1:0] wdata,
  output logic [DEPTH_W-1:0] depth_q,
  output logic               ready
);
  logic [DEPTH_W-1:0] fill_q;
  logic               fill_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= DEPTH_W'(DEFAULT_DEPTH);
      fill_q  <= '0;
    end else if (we) begin
      depth_q <= wdata;
      fill_q  <= wdata;
    end else if (fill_q != '0) begin
      fill_q  <= fill_q - 1'b1;
    end
  end

  assign fill_done = (fill_q == '0);
  assign ready     = fill_done && !we;

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !fill_done) |=> fill_q == $past(fill_q) - 1'b1); // R6
  AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> depth_q == $past(wdata)); // R6
endmodule

// File: rtl/throttle_gather.sv
module throttle_gather #(
  parameter int BOARDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BOARDS-1:0] thr_in,
  output logic [BOARDS-1:0] thr_vec,
  output logic              thr_any
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_vec <= '0;
      thr_any <= 1'b0;
    end else begin
      thr_vec <= thr_in;
      thr_any <= |thr_in;
    end
  end

  AST_THR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> thr_vec == $past(thr_in)); // R8
  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    thr_any == (thr_vec != '0)); // R9
endmodule

// File: rtl/trig_realign_relay.sv
module trig_realign_relay
  import trig_relay_pkg::*;
#(
  parameter int DEPTH_W       = 8,
  parameter int BOARDS        = 16,
  parameter int DEFAULT_DEPTH = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [43:0]        cmd_in,
  input  logic               depth_we,
  input  logic [DEPTH_W-1:0] depth_wdata,
  input  logic [BOARDS-1:0]  thr_in,
  output logic [43:0]        cmd_out,
  output logic               cmd_valid,
  output logic [BOARDS-1:0]  thr_vec,
  output logic               thr_any
);
  logic [DEPTH_W-1:0] depth_q;
  logic               pipe_ready;
  early_t             early_now;
  early_t             early_dly;
  word_t              merged;

  assign early_now = early_of(cmd_in);

  refill_guard #(.DEPTH_W(DEPTH_W), .DEFAULT_DEPTH(DEFAULT_DEPTH)) u_guard (
    .clk(clk), .rst_n(rst_n), .we(depth_we), .wdata(depth_wdata),
    .depth_q(depth_q), .ready(pipe_ready)
  );

  field_delay_line #(.DW(EARLY_W), .AW(DEPTH_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(early_now), .depth(depth_q), .dout(early_dly)
  );

  throttle_gather #(.BOARDS(BOARDS)) u_thr (
    .clk(clk), .rst_n(rst_n), .thr_in(thr_in), .thr_vec(thr_vec), .thr_any(thr_any)
  );

  assign merged = join_word(early_dly, late_of(cmd_in));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_out   <= '0;
    end else begin
      cmd_valid <= pipe_ready;
      cmd_out   <= pipe_ready ? merged : '0;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> cmd_out == '0); // R7
  AST_TRIG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_out[LATE_HI:LATE_LO] == $past(cmd_in[LATE_HI:LATE_LO])); // R3
  AST_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    depth_we |=> !cmd_valid); // R6
endmodule

// File: tb/trig_realign_relay_test.sv
module trig_realign_relay_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [43:0] cmd_in = '0;
  logic        depth_we = 1'b0;
  logic [7:0]  depth_wdata = '0;
  logic [15:0] thr_in = '0;
  logic [43:0] cmd_out;
  logic        cmd_valid;
  logic [15:0] thr_vec;
  logic        thr_any;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int last_we  = -100000;
  int cur_d    = 0;
  logic [43:0] hist [512];

  always #10 clk = ~clk;

  trig_realign_relay uut (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .depth_we(depth_we),
    .depth_wdata(depth_wdata), .thr_in(thr_in), .cmd_out(cmd_out),
    .cmd_valid(cmd_valid), .thr_vec(thr_vec), .thr_any(thr_any)
  );

  function automatic logic [43:0] pat(input int j);
    logic [63:0] x;
    x = 64'(j + 1) * 64'h9E3779B97F4A7C15;
    return x[60:17];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic tick(input logic we, input logic [7:0] wd, input logic [15:0] thr);
    logic [43:0] w, e_word, old;
    logic        e_valid;
    w = pat(cyc);
    cmd_in = w; depth_we = we; depth_wdata = wd; thr_in = thr;
    hist[cyc % 512] = w;
    if (we) begin last_we = cyc; cur_d = int'(wd); end
    @(posedge clk);
    #5;
    e_valid = !we && (cyc > last_we + cur_d);
    chk(cmd_valid == e_valid, "R6", 64'(cmd_valid), 64'(e_valid));
    if (e_valid) begin
      old = hist[(cyc - cur_d) % 512];
      e_word = w;
      e_word[19:0]  = old[19:0];
      e_word[43:41] = old[43:41];
      chk(cmd_out[40:20] == w[40:20], "R3", 64'(cmd_out[40:20]), 64'(w[40:20]));
      if (cur_d == 0)
        chk(cmd_out == w, "R5", 64'(cmd_out), 64'(w));
      else if (cur_d == 255)
        chk(cmd_out == e_word, "R10", 64'(cmd_out), 64'(e_word));
      else
        chk(cmd_out == e_word, "R4", 64'(cmd_out), 64'(e_word));
      if (cur_d == 3)
        chk(cmd_out[20] == w[20] && cmd_out[11:0] == old[11:0], "R2",
            64'({cmd_out[20], cmd_out[11:0]}), 64'({w[20], old[11:0]}));
    end else begin
      chk(cmd_out == '0, "R7", 64'(cmd_out), 64'h0);
    end
    chk(thr_vec == thr, "R8", 64'(thr_vec), 64'(thr));
    chk(thr_any == (thr != 16'h0), "R9", 64'(thr_any), 64'(thr != 16'h0));
    cyc++;
  endtask

  function automatic logic [15:0] thr_pat(input int j);
    if (j % 23 == 0) return 16'hFFFF;
    if (j % 17 == 16) return 16'h0000;
    return 16'h0001 << (j % 17);
  endfunction

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 8'h0, thr_pat(cyc));
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int dl [9] = '{1, 2, 3, 7, 0, 31, 255, 4, 4};
    cmd_in = pat(0); thr_in = 16'hA5A5;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5;
      chk(cmd_valid == 1'b0 && cmd_out == '0, "R1", 64'(cmd_out), 64'h0);
      chk(thr_vec == '0 && thr_any == 1'b0, "R1", 64'(thr_vec), 64'h0);
    end
    rst_n = 1'b1;
    run(30);
    foreach (dl[k]) begin
      tick(1'b1, 8'(dl[k]), thr_pat(cyc));
      run(dl[k] + 15);
    end
    tick(1'b1, 8'd10, 16'h8001);
    run(3);
    tick(1'b1, 8'd2, 16'h0);
    run(20);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule